// File: doc/BRIEF.md
# Data-Ready Triggered Serial Result Reader

This block sits on the host side of a multi-channel converter. It watches the converter's active-low data-ready line. Each falling edge on that line starts one serial read of the 96-bit result register, with no further request from the host. The block drives chip select, the serial clock and the outgoing data line. It shifts out a read command byte, then shifts in 96 result bits. The result appears as four 24-bit channel words, together with a one-cycle valid strobe.

The serial clock idles low. Its half-period, counted in system clock cycles, is the programmable divide input plus one. The host changes its outgoing bit when the serial clock rises. It samples the incoming bit when the serial clock falls, so the converter can shift on rising edges and capture on falling edges. A data-ready edge that arrives while a read is still in progress does not restart the read. It raises an overrun strobe instead.

Top module: `drdy_spi_reader`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `ch_valid` is 0 and `overrun` is 0.
- R2: When `drdy_n` falls while the block is idle, `spi_cs_n` goes low on the third rising clock edge after the change (two synchronizer stages plus one edge-detect stage).
- R3: The first 8 bits presented on `spi_mosi` at the falling edges of `spi_sclk` are the read command, sent MSB first. The command is a 1 (read flag) followed by the 7-bit parameter `RD_ADDR`.
- R4: Each transaction contains exactly 104 `spi_sclk` pulses while `spi_cs_n` is low. `spi_sclk` is 0 whenever `spi_cs_n` is high.
- R5: Each `spi_sclk` high phase and low phase lasts `div_half`+1 clock cycles. The same interval separates the fall of `spi_cs_n` from the first rising edge of `spi_sclk`, and the last falling edge of `spi_sclk` from the rise of `spi_cs_n`.
- R6: While `spi_cs_n` stays low, `spi_mosi` changes only in the cycle in which `spi_sclk` rises.
- R7: `spi_miso` is sampled at the falling edges of `spi_sclk` 9 through 104. The first bit sampled is result bit 95. Channel 0 is result bits 95..72 and appears on `ch_words[95:72]`; channel 3 is result bits 23..0 and appears on `ch_words[23:0]`.
- R8: `ch_valid` is a single-cycle pulse, once per transaction. It is asserted one cycle after `spi_cs_n` rises, while `spi_cs_n` is still high. `ch_words` holds its value until the next pulse.
- R9: A falling edge of `drdy_n` detected while a transaction or its trailing gap is in progress produces a one-cycle `overrun` pulse. It does not start a new transaction, and the current transaction still ends with exactly one `ch_valid`.
- R10: Between transactions, `spi_cs_n` stays high for at least 2×(`div_half`+1) clock cycles.
- R11: A rising edge of `drdy_n` starts nothing: `spi_cs_n` stays high and `ch_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Serial clock half-period minus one, in clk cycles |
| drdy_n | input | 1 | Active-low data-ready line from the converter (asynchronous) |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the converter (command byte, then zeros) |
| ch_words | output | 4×24 | Four channel words; channel 0 in the most significant bits |
| ch_valid | output | 1 | One-cycle strobe marking new `ch_words` |
| overrun | output | 1 | One-cycle strobe for a data-ready edge seen while busy |

## Verification
A wrong bit counter or a wrong state in the sequencer shows up at once in the pulse count of `spi_sclk` or the command pattern. The result words are then shifted by one bit, so the first transaction fails, within about 210 half-periods. A wrong divider count changes the measured half-period at the very next serial clock edge. A broken busy decision shows up as a second chip-select fall, or as a missing `overrun` pulse, within the transaction in which the extra data-ready edge arrives.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
    localparam int WORD_W    = 24;
    localparam int NUM_CH    = 4;
    localparam int FRAME_W   = WORD_W * NUM_CH;
    localparam int ADDR_W    = 7;
    localparam int CMD_W     = ADDR_W + 1;
    localparam int XFER_BITS = CMD_W + FRAME_W;
    localparam int BITCNT_W  = $clog2(XFER_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP1,
        ST_GAP2
    } xfer_state_t;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [WORD_W-1:0]  word_t;

    function automatic logic [CMD_W-1:0] read_cmd(input logic [ADDR_W-1:0] addr);
        return {1'b1, addr};
    endfunction
endpackage

// File: rtl/rdr_drdy_edge.sv
module rdr_drdy_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic drdy_n,
    output logic fall
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-1:0], drdy_n};
    end

    assign fall = sync_q[STAGES] & ~sync_q[STAGES-1];
endmodule

// File: rtl/rdr_half_tick.sv
module rdr_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)        cnt_q <= div_half;
        else if (cnt_q == '0)  cnt_q <= div_half;
        else                   cnt_q <= cnt_q - 1'b1;
    end

    assign tick = en && (cnt_q == '0);
endmodule

// File: rtl/rdr_xfer_fsm.sv
module rdr_xfer_fsm
    import rdr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RD_ADDR = 7'h00
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   tick,
    input  logic   miso,
    output logic   busy,
    output logic   cs_n,
    output logic   sclk,
    output logic   mosi,
    output frame_t frame,
    output logic   done
);
    localparam logic [CMD_W-1:0]    CMD      = read_cmd(RD_ADDR);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(XFER_BITS - 1);
    localparam logic [BITCNT_W-1:0] DATA_BIT = BITCNT_W'(CMD_W);

    xfer_state_t         st_q;
    logic [CMD_W-1:0]    cmd_sr;
    logic [BITCNT_W-1:0] bit_cnt;
    frame_t              rx_sr;
    logic                cs_n_q, sclk_q, mosi_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cmd_sr  <= '0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    cs_n_q  <= 1'b0;
                    cmd_sr  <= CMD;
                    mosi_q  <= CMD[CMD_W-1];
                    bit_cnt <= '0;
                    st_q    <= ST_SETUP;
                end
                ST_SETUP: if (tick) begin
                    sclk_q <= 1'b1;
                    st_q   <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sclk_q <= 1'b0;
                    if (bit_cnt >= DATA_BIT) rx_sr <= {rx_sr[FRAME_W-2:0], miso};
                    bit_cnt <= bit_cnt + 1'b1;
                    st_q    <= (bit_cnt == LAST_BIT) ? ST_TAIL : ST_LOW;
                end
                ST_LOW: if (tick) begin
                    sclk_q <= 1'b1;
                    cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
                    mosi_q <= cmd_sr[CMD_W-2];
                    st_q   <= ST_HIGH;
                end
                ST_TAIL: if (tick) begin
                    cs_n_q <= 1'b1;
                    mosi_q <= 1'b0;
                    done_q <= 1'b1;
                    st_q   <= ST_GAP1;
                end
                ST_GAP1: if (tick) st_q <= ST_GAP2;
                ST_GAP2: if (tick) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (st_q != ST_IDLE);
    assign cs_n  = cs_n_q;
    assign sclk  = sclk_q;
    assign mosi  = mosi_q;
    assign frame = rx_sr;
    assign done  = done_q;
endmodule

// File: rtl/drdy_spi_reader.sv
module drdy_spi_reader
    import rdr_pkg::*;
#(
    parameter int                DIV_W   = 8,
    parameter logic [ADDR_W-1:0] RD_ADDR = 7'h00
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DIV_W-1:0]           div_half,
    input  logic                       drdy_n,
    input  logic                       spi_miso,
    output logic                       spi_cs_n,
    output logic                       spi_sclk,
    output logic                       spi_mosi,
    output logic [NUM_CH*WORD_W-1:0]   ch_words,
    output logic                       ch_valid,
    output logic                       overrun
);
    logic   fall, tick, busy, done;
    frame_t frame;
    word_t  word_q [NUM_CH];
    logic   valid_q, ovr_q;

    rdr_drdy_edge #(.STAGES(2)) u_edge (
        .clk(clk), .rst(rst), .drdy_n(drdy_n), .fall(fall)
    );

    rdr_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .en(busy), .div_half(div_half), .tick(tick)
    );

    rdr_xfer_fsm #(.RD_ADDR(RD_ADDR)) u_fsm (
        .clk(clk), .rst(rst), .start(fall), .tick(tick), .miso(spi_miso),
        .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .frame(frame), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            for (int i = 0; i < NUM_CH; i++) word_q[i] <= '0;
        end else begin
            valid_q <= done;
            ovr_q   <= fall && busy;
            if (done)
                for (int i = 0; i < NUM_CH; i++)
                    word_q[i] <= frame[(NUM_CH-1-i)*WORD_W +: WORD_W];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_words[(NUM_CH-1-g)*WORD_W +: WORD_W] = word_q[g];
    end

    assign ch_valid = valid_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/rdr_checker.sv
module rdr_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_half,
    input logic             spi_cs_n,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             ch_valid,
    input logic             overrun
);
    logic [DIV_W+1:0] hi_cnt;
    logic [DIV_W+1:0] need;

    assign need = {1'b0, div_half, 1'b0} + (DIV_W+2)'(2);

    always_ff @(posedge clk) begin
        if (rst)                 hi_cnt <= '1;
        else if (!spi_cs_n)      hi_cnt <= '0;
        else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
    end

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> $rose(spi_sclk));

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        ch_valid |=> !ch_valid);

    p_valid_cs_r8: assert property (@(posedge clk) disable iff (rst)
        ch_valid |-> spi_cs_n);

    p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
        overrun |-> !$fell(spi_cs_n));

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (hi_cnt >= need));
endmodule

bind drdy_spi_reader rdr_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .div_half(div_half), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .ch_valid(ch_valid),
    .overrun(overrun)
);

// File: tb/drdy_spi_reader_bench.sv
module drdy_spi_reader_bench;
    localparam int          DIV_W = 4;
    localparam logic [6:0]  ADDR  = 7'h5A;

    logic        clk = 0;
    logic        rst = 1;
    logic [DIV_W-1:0] div_half = '0;
    logic        drdy_n = 1;
    logic        spi_miso = 0;
    logic        spi_cs_n, spi_sclk, spi_mosi, ch_valid, overrun;
    logic [95:0] ch_words;

    always #2 clk = ~clk;

    drdy_spi_reader #(.DIV_W(DIV_W), .RD_ADDR(ADDR)) u_drdy_spi_reader (
        .clk(clk), .rst(rst), .div_half(div_half), .drdy_n(drdy_n),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .ch_words(ch_words), .ch_valid(ch_valid),
        .overrun(overrun)
    );

    int total = 0;
    int bad = 0;

    // monitor / device-model state
    logic [95:0] frame = '0;
    int   cur_div = 0;
    logic sclk_q = 0, cs_q = 1, mosi_q = 0;
    int   rises = 0, falls = 0, hp_cnt = 0, gap_cnt = 0;
    int   hp_bad = 0, mosi_bad = 0, idle_bad = 0, gap_bad = 0;
    int   vcount = 0, ocount = 0, cs_falls = 0;
    bit   seen_xfer = 0;
    logic [7:0] cmd_cap = '0;

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            sclk_q = 0; cs_q = 1; mosi_q = 0;
        end else begin
            hp_cnt++;
            if (cs_q && !spi_cs_n) begin
                cs_falls++;
                if (seen_xfer && gap_cnt < 2*(cur_div+1)) gap_bad++;
                rises = 0; falls = 0; cmd_cap = '0; hp_cnt = 0;
            end else if (!cs_q && spi_cs_n) begin
                if (hp_cnt != cur_div+1) hp_bad++;
                seen_xfer = 1; gap_cnt = 0;
            end
            if (spi_cs_n) gap_cnt++;
            if (spi_sclk != sclk_q) begin
                if (hp_cnt != cur_div+1) hp_bad++;
                hp_cnt = 0;
                if (spi_sclk) begin
                    rises++;
                    if (rises >= 9 && rises <= 104) spi_miso = frame[104-rises];
                end else begin
                    falls++;
                    if (falls <= 8) cmd_cap = {cmd_cap[6:0], spi_mosi};
                end
            end
            if (!spi_cs_n && !cs_q && spi_mosi != mosi_q && !(spi_sclk && !sclk_q)) mosi_bad++;
            if (spi_cs_n && spi_sclk) idle_bad++;
            if (ch_valid) vcount++;
            if (overrun) ocount++;
            sclk_q = spi_sclk; cs_q = spi_cs_n; mosi_q = spi_mosi;
        end
    end

    function automatic logic [95:0] mk_frame(input int n);
        logic [95:0] f;
        for (int k = 0; k < 4; k++)
            f[(3-k)*24 +: 24] = 24'((k+1)*24'h13579B) ^ 24'(n*24'h0A0F1);
        return f;
    endfunction

    task automatic finish_checks(input int d, input logic [95:0] f, input int v0, input int h0,
                                 input int c0, input int o_exp, input int o0);
        logic [95:0] cap;
        int w;
        w = 0;
        while (!ch_valid && w < 8000) begin @(negedge clk); w++; end
        cap = ch_words;
        chk(ch_valid, "R8 valid seen", 96'(ch_valid), 96'd1);
        chk(spi_cs_n, "R8 cs high at valid", 96'(spi_cs_n), 96'd1);
        for (int k = 0; k < 4; k++)
            chk(cap[(3-k)*24 +: 24] == f[(3-k)*24 +: 24], "R7 channel word",
                96'(cap[(3-k)*24 +: 24]), 96'(f[(3-k)*24 +: 24]));
        repeat (2*(d+1)+3) @(negedge clk);
        #1;
        chk(ch_words == f, "R8 words held", ch_words, f);
        chk(vcount - v0 == 1, "R8 one valid", 96'(vcount - v0), 96'd1);
        chk(cmd_cap == {1'b1, ADDR}, "R3 command byte", 96'(cmd_cap), 96'({1'b1, ADDR}));
        chk(falls == 104 && rises == 104, "R4 pulse count", 96'(falls), 96'd104);
        chk(hp_bad == h0, "R5 half period", 96'(hp_bad - h0), 96'd0);
        chk(mosi_bad == 0, "R6 mosi stable", 96'(mosi_bad), 96'd0);
        chk(idle_bad == 0, "R4 sclk idle low", 96'(idle_bad), 96'd0);
        chk(gap_bad == 0, "R10 cs gap", 96'(gap_bad), 96'd0);
        chk(cs_falls - c0 == 1, "R9 single cs fall", 96'(cs_falls - c0), 96'd1);
        chk(ocount - o0 == o_exp, "R9 overrun count", 96'(ocount - o0), 96'(o_exp));
    endtask

    task automatic run_xfer(input int d, input logic [95:0] f);
        int lat, v0, h0, c0, o0;
        cur_div = d; div_half = DIV_W'(d); frame = f;
        drdy_n = 1;
        repeat (40) @(negedge clk);
        #1;
        v0 = vcount; h0 = hp_bad; c0 = cs_falls; o0 = ocount;
        drdy_n = 0;
        lat = 0;
        while (spi_cs_n && lat < 10) begin @(negedge clk); lat++; end
        chk(lat == 3, "R2 start latency", 96'(lat), 96'd3);
        finish_checks(d, f, v0, h0, c0, 0, o0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int v0, h0, c0, o0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(spi_cs_n == 1, "R1 cs_n reset", 96'(spi_cs_n), 96'd1);
        chk(spi_sclk == 0, "R1 sclk reset", 96'(spi_sclk), 96'd0);
        chk(ch_valid == 0, "R1 valid reset", 96'(ch_valid), 96'd0);
        chk(overrun == 0, "R1 overrun reset", 96'(overrun), 96'd0);

        n = 0;
        run_xfer(0, '1);
        run_xfer(0, '0);
        foreach (cur_div_list[i]) begin
            run_xfer(cur_div_list[i], mk_frame(n)); n++;
            run_xfer(cur_div_list[i], mk_frame(n)); n++;
        end

        // R9: second data-ready edge in the middle of a transfer
        cur_div = 2; div_half = 2; frame = mk_frame(99);
        drdy_n = 1;
        repeat (40) @(negedge clk);
        #1;
        v0 = vcount; h0 = hp_bad; c0 = cs_falls; o0 = ocount;
        drdy_n = 0;
        repeat (40) @(negedge clk);
        drdy_n = 1;
        repeat (4) @(negedge clk);
        drdy_n = 0;
        finish_checks(2, frame, v0, h0, c0, 1, o0);

        // R11: rising edge while idle starts nothing
        repeat (20) @(negedge clk);
        #1;
        v0 = vcount; c0 = cs_falls;
        drdy_n = 1;
        repeat (30) @(negedge clk);
        #1;
        chk(cs_falls == c0 && spi_cs_n, "R11 no start on rise", 96'(cs_falls - c0), 96'd0);
        chk(vcount == v0, "R11 no valid on rise", 96'(vcount - v0), 96'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int cur_div_list [5] = '{1, 2, 3, 7, 15};
endmodule